// File: doc/BRIEF.md
# Retriggerable Down-Counting Timer

This block is a down-counting interval timer. A prescaler and a main counter, each 8 bits wide by default, are chained. One count step takes a full prescaler pass, so the programmed interval is the prescaler value times the counter value. The count clock is either an internal tick or falling edges on an external pin. The internal tick is the system clock divided by 2 and then by 4, which gives one tick every 8 clocks. A two-bit role field sets what the pin does: it can act as a count clock, as a gate on the internal tick, as a one-shot trigger, or as a retrigger that restarts the interval on every falling edge.

When an interval ends, the block raises a one-cycle end-of-count pulse and toggles an output pin. That output can drive the external clock input of a second timer, which then counts once for every two intervals of this one. Every recognised falling edge on the pin also raises its own one-cycle pulse. In single-pass operation, end-of-count drops the run flag, and software must restart the timer. In continuous operation, both stages reload and counting carries on. Control is through plain pins: reload values, a role field, a repeat bit, and load, start and stop strobes. The block carries no data stream, so no port has a valid/ready handshake.

Top module: `rtt_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `run_en`, `cnt_now`, `eoc_irq`, `fall_irq` and `tout` are all 0.
- R2: The internal tick occurs every 8 clocks and restarts from zero on every load. An interval lasts `pre_reload` × `cnt_reload` steps, where a reload value of 0 stands for 256. `eoc_irq` is high for exactly one clock, starting one clock after the step at which both stages stand at 1.
- R3: `tin` passes through two synchroniser flops. A recognised falling edge gives a one-clock `fall_irq` pulse. The pulse appears two clocks after the clock edge that first samples `tin` low. This happens in every role, whether or not the timer is running.
- R4: With role 2'b00 (pin clock), each recognised falling edge is one count step. With reloads 1 and 0, the 256th edge ends the interval.
- R5: With role 2'b01 (gate), internal ticks count only while the synchronised `tin` is high. While it is low, `cnt_now` holds.
- R6: With role 2'b10 (trigger), a running timer does not count until the first recognised edge. That edge reloads both stages and restarts the tick. Later edges leave the interval unchanged.
- R7: With role 2'b11 (retrigger), every recognised edge while running reloads both stages and restarts the tick. Edges spaced closer than the interval therefore prevent `eoc_irq`.
- R8: With `cfg_repeat`=0, end-of-count clears `run_en`. Later edges then change neither `cnt_now` nor `eoc_irq` until `sw_start` is pulsed.
- R9: With `cfg_repeat`=1, both stages reload at end-of-count and `eoc_irq` repeats every interval: 48 clocks for reloads 2 and 3 on the internal tick.
- R10: If a retrigger edge and an end-of-count fall in the same cycle, the reload wins and no `eoc_irq` is produced for that cycle.
- R11: `tout` inverts in the same cycle that `eoc_irq` is high, and holds otherwise.
- R12: `sw_load` copies both reload values into the stages and restarts the tick. `sw_start` sets `run_en`. `sw_stop` clears it, and wins over `sw_start`.
- R13: `cnt_now` always shows the current main counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_role | input | 2 | Pin role: 00 clock, 01 gate, 10 trigger, 11 retrigger |
| cfg_repeat | input | 1 | 1 continuous, 0 single-pass |
| pre_reload | input | 8 | Prescaler reload value (0 = 256) |
| cnt_reload | input | 8 | Counter reload value (0 = 256) |
| sw_load | input | 1 | Strobe: load both stages |
| sw_start | input | 1 | Strobe: set run flag |
| sw_stop | input | 1 | Strobe: clear run flag |
| tin | input | 1 | External timer pin, asynchronous |
| run_en | output | 1 | Run flag |
| cnt_now | output | 8 | Current main counter value |
| eoc_irq | output | 1 | End-of-count pulse |
| fall_irq | output | 1 | Pin falling-edge pulse |
| tout | output | 1 | Toggles at each end-of-count |

## Verification
In retrigger mode, a recognised pin edge and an end-of-count can land in the same cycle. The bench provokes this with reloads of 1 and 1, which give an 8-clock interval. It then drives a square wave on `tin` with an 8-clock period, so every edge reaches the counter exactly on the tick that would end the interval. The outcome is judged in two ways: no `eoc_irq` may appear while the fall pulses keep their full count, and a per-cycle behavioural model must agree on every output in every cycle.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    PIN_CLOCK     = 2'b00,
    PIN_GATE      = 2'b01,
    PIN_TRIGGER   = 2'b10,
    PIN_RETRIGGER = 2'b11
  } pin_role_e;
endpackage

// File: rtl/rtt_edge_sync.sv
module rtt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  // shift chain idles high; last stage holds the previous synchronised sample
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
  end

  assign level = sh_q[SYNC_STAGES-1];
  assign fall  = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/rtt_tick_gen.sv
module rtt_tick_gen #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DIV = DIV_A * DIV_B;
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (clr)           div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/rtt_down_core.sv
module rtt_down_core #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PRE_W-1:0] pre_rl,
  input  logic [CNT_W-1:0] cnt_rl,
  output logic [CNT_W-1:0] cnt_q,
  output logic             term
);
  logic [PRE_W-1:0] pre_q;
  logic pre_last, cnt_last;

  assign pre_last = (pre_q == PRE_W'(1));
  assign cnt_last = (cnt_q == CNT_W'(1));
  assign term     = step & pre_last & cnt_last;

  // a value of 0 wraps through all ones, so it spans the full 2**W range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= pre_rl;
      cnt_q <= cnt_rl;
    end else if (step) begin
      if (pre_last) begin
        pre_q <= pre_rl;
        cnt_q <= cnt_last ? cnt_rl : cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer #(
  parameter int PRE_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_role,
  input  logic             cfg_repeat,
  input  logic [PRE_W-1:0] pre_reload,
  input  logic [CNT_W-1:0] cnt_reload,
  input  logic             sw_load,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             tin,
  output logic             run_en,
  output logic [CNT_W-1:0] cnt_now,
  output logic             eoc_irq,
  output logic             fall_irq,
  output logic             tout
);
  import rtt_pkg::*;

  pin_role_e role;
  logic pin_level, pin_fall, int_tick;
  logic run_q, armed_q;
  logic trig_load, core_load, step, term, eoc;

  assign role = pin_role_e'(cfg_role);

  rtt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(tin), .level(pin_level), .fall(pin_fall)
  );

  rtt_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(core_load), .tick(int_tick)
  );

  // edge-driven load: retrigger on every edge, trigger only on the first
  assign trig_load = run_q & pin_fall &
                     ((role == PIN_RETRIGGER) | ((role == PIN_TRIGGER) & ~armed_q));
  assign core_load = sw_load | trig_load;

  always_comb begin
    unique case (role)
      PIN_CLOCK: step = run_q & pin_fall;
      PIN_GATE:  step = run_q & pin_level & int_tick;
      default:   step = run_q & armed_q & int_tick;
    endcase
  end

  rtt_down_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(core_load), .step(step),
    .pre_rl(pre_reload), .cnt_rl(cnt_reload), .cnt_q(cnt_now), .term(term)
  );

  // a reload in the same cycle cancels the end-of-count
  assign eoc = term & ~core_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      eoc_irq  <= 1'b0;
      fall_irq <= 1'b0;
      tout     <= 1'b0;
    end else begin
      if (sw_stop)                  run_q <= 1'b0;
      else if (sw_start)            run_q <= 1'b1;
      else if (eoc && !cfg_repeat)  run_q <= 1'b0;

      if (!run_q || sw_stop || (eoc && !cfg_repeat)) armed_q <= 1'b0;
      else if (trig_load)                            armed_q <= 1'b1;

      eoc_irq  <= eoc;
      fall_irq <= pin_fall;
      if (eoc) tout <= ~tout;
    end
  end

  assign run_en = run_q;
endmodule

// File: rtl/rtt_timer_chk.sv
module rtt_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_start,
  input logic sw_stop,
  input logic run_en,
  input logic eoc_irq,
  input logic fall_irq,
  input logic tout
);
  p_eoc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_irq |=> !fall_irq);

  p_tout_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> (tout != $past(tout)));

  p_tout_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_irq |-> $stable(tout));

  p_run_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> ($past(sw_stop) || eoc_irq));

  p_run_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> ($past(sw_start) && !$past(sw_stop)));
endmodule

bind rtt_timer rtt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop),
  .run_en(run_en), .eoc_irq(eoc_irq), .fall_irq(fall_irq), .tout(tout)
);

// File: tb/rtt_timer_test.sv
module rtt_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_role = 2'b00;
  logic cfg_repeat = 1'b0;
  logic [7:0] pre_reload = 8'd0, cnt_reload = 8'd0;
  logic sw_load = 1'b0, sw_start = 1'b0, sw_stop = 1'b0, tin = 1'b1;
  logic run_en, eoc_irq, fall_irq, tout;
  logic [7:0] cnt_now;

  int n_chk = 0, n_bad = 0, n_eoc = 0, n_fall = 0, cyc = 0;

  rtt_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role), .cfg_repeat(cfg_repeat),
    .pre_reload(pre_reload), .cnt_reload(cnt_reload), .sw_load(sw_load),
    .sw_start(sw_start), .sw_stop(sw_stop), .tin(tin), .run_en(run_en),
    .cnt_now(cnt_now), .eoc_irq(eoc_irq), .fall_irq(fall_irq), .tout(tout)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped at each rising edge
  int m_s0 = 1, m_s1 = 1, m_s2 = 1, m_div = 0, m_pre = 0, m_cnt = 0;
  int m_run = 0, m_arm = 0, m_eoc = 0, m_fall = 0, m_tout = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = 1; m_s1 = 1; m_s2 = 1; m_div = 0; m_pre = 0; m_cnt = 0;
      m_run = 0; m_arm = 0; m_eoc = 0; m_fall = 0; m_tout = 0;
    end else begin
      int fl, lv, tk, tl, ld, st, eo;
      fl = (m_s2 == 1 && m_s1 == 0);
      lv = m_s1;
      tk = (m_div == 7);
      tl = m_run && fl && (cfg_role == 3 || (cfg_role == 2 && !m_arm));
      ld = sw_load || tl;
      if (cfg_role == 0)      st = m_run && fl;
      else if (cfg_role == 1) st = m_run && lv && tk;
      else                    st = m_run && m_arm && tk;
      eo = st && m_pre == 1 && m_cnt == 1 && !ld;
      m_div = ld ? 0 : (m_div + 1) % 8;
      if (ld) begin m_pre = pre_reload; m_cnt = cnt_reload; end
      else if (st) begin
        if (m_pre == 1) begin
          m_pre = pre_reload;
          m_cnt = (m_cnt == 1) ? int'(cnt_reload) : (m_cnt - 1) & 255;
        end else m_pre = (m_pre - 1) & 255;
      end
      if (!m_run || sw_stop || (eo && !cfg_repeat)) m_arm = 0;
      else if (tl) m_arm = 1;
      if (sw_stop) m_run = 0;
      else if (sw_start) m_run = 1;
      else if (eo && !cfg_repeat) m_run = 0;
      m_eoc = eo; m_fall = fl;
      if (eo) m_tout = 1 - m_tout;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = tin;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (eoc_irq) n_eoc++;
    if (fall_irq) n_fall++;
    if (rst_n) begin
      chk(run_en == m_run, "R8 run_en", run_en, m_run);
      chk(cnt_now == m_cnt, "R13 cnt_now", cnt_now, m_cnt);
      chk(eoc_irq == m_eoc, "R2 eoc_irq", eoc_irq, m_eoc);
      chk(fall_irq == m_fall, "R3 fall_irq", fall_irq, m_fall);
      chk(tout == m_tout, "R11 tout", tout, m_tout);
    end
    if (cyc > 200000) begin
      chk(1'b0, "watchdog", cyc, 200000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_load();  sw_load = 1;  @(negedge clk); sw_load = 0;  endtask
  task automatic do_start(); sw_start = 1; @(negedge clk); sw_start = 0; endtask
  task automatic do_stop();  sw_stop = 1;  @(negedge clk); sw_stop = 0;  endtask
  task automatic fall_edge(input int lo, input int hi);
    tin = 0; idle(lo); tin = 1; idle(hi);
  endtask
  task automatic wait_eoc(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!eoc_irq && c < 5000);
  endtask
  task automatic snap(output int e, output int f);
    #2 e = n_eoc; f = n_fall;
  endtask

  initial begin
    int c, e0, f0, e1, f1, hold;
    idle(3);
    chk(run_en == 0 && cnt_now == 0 && eoc_irq == 0 && fall_irq == 0 && tout == 0,
        "R1 reset state", {run_en, eoc_irq, fall_irq, tout}, 0);
    rst_n = 1; idle(2);
    chk(run_en == 0 && cnt_now == 0 && tout == 0, "R1 after release", cnt_now, 0);

    // continuous retrigger, interval 2*3 ticks of 8 clocks
    cfg_role = 2'b11; cfg_repeat = 1; pre_reload = 2; cnt_reload = 3;
    do_load();
    chk(cnt_now == 3, "R12 load", cnt_now, 3);
    do_start(); fall_edge(3, 3);
    wait_eoc(c); wait_eoc(c);
    chk(c == 48, "R9 period", c, 48);
    wait_eoc(c);
    chk(c == 48, "R9 period again", c, 48);

    // retrigger faster than the interval suppresses end-of-count
    snap(e0, f0);
    repeat (8) fall_edge(10, 20);
    snap(e1, f1);
    chk(e1 == e0, "R7 no eoc while retriggered", e1 - e0, 0);
    chk(f1 - f0 == 8, "R3 fall count", f1 - f0, 8);
    wait_eoc(c);
    chk(c < 60, "R7 eoc after last edge", c, 48);
    do_stop();
    chk(run_en == 0, "R12 stop", run_en, 0);
    sw_start = 1; sw_stop = 1; @(negedge clk); sw_start = 0; sw_stop = 0;
    chk(run_en == 0, "R12 stop wins", run_en, 0);

    // collision: edges land exactly on the terminal tick
    pre_reload = 1; cnt_reload = 1; do_load(); do_start();
    snap(e0, f0);
    repeat (15) fall_edge(4, 4);
    snap(e1, f1);
    chk(e1 == e0, "R10 reload beats eoc", e1 - e0, 0);
    chk(f1 - f0 == 15, "R3 fall pulses", f1 - f0, 15);
    do_stop(); idle(12);

    // single-pass trigger
    cfg_role = 2'b10; cfg_repeat = 0; pre_reload = 1; cnt_reload = 2;
    do_load(); do_start(); idle(20);
    chk(cnt_now == 2, "R6 waits for trigger", cnt_now, 2);
    fall_edge(3, 3); wait_eoc(c);
    idle(2);
    chk(run_en == 0, "R8 single-pass clears run", run_en, 0);
    hold = cnt_now; snap(e0, f0);
    repeat (3) fall_edge(3, 20);
    snap(e1, f1);
    chk(e1 == e0, "R8 edges ignored eoc", e1 - e0, 0);
    chk(cnt_now == hold, "R8 edges ignored cnt", cnt_now, hold);
    do_start(); fall_edge(3, 3); wait_eoc(c);
    chk(c < 20, "R8 restart works", c, 16);

    // continuous trigger: extra edges do not restart
    cfg_repeat = 1; do_start(); fall_edge(3, 3); wait_eoc(c);
    fork
      wait_eoc(c);
      repeat (2) fall_edge(2, 3);
    join
    chk(c == 16, "R6 later edges ignored", c, 16);
    do_stop(); idle(4);

    // gate mode
    cfg_role = 2'b01; pre_reload = 1; cnt_reload = 10; tin = 0; idle(4);
    do_load(); do_start(); idle(40);
    chk(cnt_now == 10, "R5 gate closed", cnt_now, 10);
    tin = 1; idle(40);
    chk(cnt_now != 10, "R5 gate open", cnt_now, 5);
    do_stop(); idle(4);

    // pin as clock, counter 0 stands for 256
    cfg_role = 2'b00; pre_reload = 1; cnt_reload = 0;
    do_load(); do_start(); snap(e0, f0);
    repeat (255) fall_edge(2, 2);
    snap(e1, f1);
    chk(e1 == e0, "R4 255 edges", e1 - e0, 0);
    fall_edge(2, 2); idle(4); snap(e1, f1);
    chk(e1 - e0 == 1, "R4 256th edge", e1 - e0, 1);
    do_stop(); idle(4);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule